// File: doc/BRIEF.md
# Undefined Opcode Trap Sequencer

This block carries out the processor's response to a fetch of an opcode that the decoder does not recognise. The trap cannot be masked: any strobe on the undefined-fetch input that arrives while the sequencer is idle is taken. When a trap is taken, the block sets a sticky trap flag in a small status register. It also records which opcode byte was the bad one, because the fault can come from the second or from the third byte of an instruction.

After taking the trap, the block writes the current program counter onto the stack, one byte per clock and most significant byte first. The stack pointer moves down by one with each byte. The block then forces the next fetch to logical address zero. Software reads the status register to find out why the trap vector was entered. It subtracts one from the stacked PC when the position bit is 0 and two when the bit is 1, which gives the start of the faulting instruction. It then writes 0 to the trap flag to acknowledge the trap.

Top module: `undef_trap_seq`

## Requirements
- R1: After a synchronous reset, the trap flag (status bit 0) and the position bit (status bit 1) read 0, all other status bits read 0, and `busy`, `mem_we`, `sp_wr_en` and `vec_load` are low.
- R2: A strobe on `undef_fetch` sampled while `busy` is low sets the trap flag at the same clock edge. No input can mask it.
- R3: The position bit takes the value of `third_byte` from the accepted strobe. It is 0 for a bad second byte (instruction start = stacked PC - 1) and 1 for a bad third byte (instruction start = stacked PC - 2).
- R4: In the first cycle after the accepted strobe, `mem_we` is high with address SP-1 and data PC[15:8]. In the next cycle it is high with address SP-2 and data PC[7:0]. SP and PC are the values sampled with the strobe.
- R5: In each push cycle, `sp_wr_en` is high and `sp_wr_val` equals that cycle's write address, so the stack pointer ends at SP-2. The arithmetic wraps modulo 2^16.
- R6: In the cycle right after the last push, `vec_load` is high for exactly one cycle with `vec_addr` = 0x0000.
- R7: `busy` is high from the cycle after the accepted strobe through the vector-load cycle (three cycles) and is low otherwise.
- R8: A strobe while `busy` is high is ignored: it does not restart the push, and it does not change the pushed data, the addresses or the position bit.
- R9: A status write with `stat_wtrap` = 0 clears the trap flag. A write with `stat_wtrap` = 1 leaves the flag unchanged. Software cannot write the position bit.
- R10: If an accepted strobe and a clearing status write fall in the same cycle, the trap flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| undef_fetch | input | 1 | Undefined-opcode fetch strobe |
| third_byte | input | 1 | 1 when the third opcode byte was undefined, 0 for the second |
| pc_in | input | 16 | Program counter to be stacked |
| sp_in | input | 16 | Current stack pointer |
| stat_wr | input | 1 | Status register write strobe |
| stat_wtrap | input | 1 | Write value for the trap flag (only 0 has an effect) |
| stat_rdata | output | 8 | Status read: bit 0 trap flag, bit 1 position bit |
| busy | output | 1 | Trap sequence in progress |
| mem_we | output | 1 | Stack byte write enable |
| mem_addr | output | 16 | Stack byte write address |
| mem_wdata | output | 8 | Stack byte write data |
| sp_wr_en | output | 1 | Stack pointer update enable |
| sp_wr_val | output | 16 | New stack pointer value |
| vec_load | output | 1 | Force next fetch address |
| vec_addr | output | 16 | Forced fetch address (logical zero) |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit bytes and a vector of zero. With these values the PC takes exactly two pushes, so the high-byte-first order can be seen directly on the write port, and an SP near zero shows the address wrapping to 0xFFFF. The 8-bit status width leaves the unused upper bits visible, so the bench can confirm they read zero. A strobe that is held high, and strobes placed during the push and vector cycles, show that a new trap is taken only once the sequencer is idle again.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PUSH = 2'd1,
        SEQ_VEC  = 2'd2
    } seq_state_e;

    localparam int STAT_TRAP_POS = 0;
    localparam int STAT_UFB_POS  = 1;

    typedef struct packed {
        logic ufb;
        logic trap;
    } trap_stat_t;

    // set has priority over a software clear; a write of 1 is a no-op
    function automatic logic next_trap(input logic cur, input logic set,
                                       input logic wr, input logic wval);
        if (set)
            return 1'b1;
        else if (wr && !wval)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/trap_status_reg.sv
module trap_status_reg
    import trap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set,
    input  logic          third,
    input  logic          wr,
    input  logic          wval,
    output trap_stat_t    stat,
    output logic [DW-1:0] rdata
);

    trap_stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.trap <= next_trap(stat_q.trap, set, wr, wval);
            if (set)
                stat_q.ufb <= third;
        end
    end

    always_comb begin
        rdata                = '0;
        rdata[STAT_TRAP_POS] = stat_q.trap;
        rdata[STAT_UFB_POS]  = stat_q.ufb;
    end

    assign stat = stat_q;

endmodule

// File: rtl/trap_push_seq.sv
module trap_push_seq
    import trap_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] VEC_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] sp,
    output logic          accepted,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          sp_wr_en,
    output logic [AW-1:0] sp_wr_val,
    output logic          vec_load,
    output logic [AW-1:0] vec_addr
);

    localparam int NB = AW / DW;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

    seq_state_e    state_q;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] sp_dec;
    logic [DW-1:0] byte_sel [NB];

    assign accepted = start && (state_q == SEQ_IDLE);
    assign sp_dec   = sp_q - AW'(1);

    // byte k of the push is PC byte NB-1-k (most significant first)
    for (genvar g = 0; g < NB; g++) begin : g_bytes
        assign byte_sel[g] = pc_q[(NB-1-g)*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_PUSH;
                        idx_q   <= '0;
                        pc_q    <= pc;
                        sp_q    <= sp;
                    end
                end
                SEQ_PUSH: begin
                    sp_q  <= sp_dec;
                    idx_q <= idx_q + IW'(1);
                    if (idx_q == LAST_IDX)
                        state_q <= SEQ_VEC;
                end
                SEQ_VEC:  state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = (state_q == SEQ_PUSH);
        mem_addr  = mem_we ? sp_dec : '0;
        mem_wdata = mem_we ? byte_sel[idx_q] : '0;
        sp_wr_en  = mem_we;
        sp_wr_val = mem_addr;
        vec_load  = (state_q == SEQ_VEC);
        vec_addr  = vec_load ? VEC_ADDR : '0;
        busy      = (state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/undef_trap_seq.sv
module undef_trap_seq
    import trap_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] VEC_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          undef_fetch,
    input  logic          third_byte,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic          stat_wr,
    input  logic          stat_wtrap,
    output logic [DW-1:0] stat_rdata,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          sp_wr_en,
    output logic [AW-1:0] sp_wr_val,
    output logic          vec_load,
    output logic [AW-1:0] vec_addr
);

    logic       accepted;
    trap_stat_t stat;

    trap_push_seq #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (undef_fetch),
        .pc        (pc_in),
        .sp        (sp_in),
        .accepted  (accepted),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp_wr_en  (sp_wr_en),
        .sp_wr_val (sp_wr_val),
        .vec_load  (vec_load),
        .vec_addr  (vec_addr)
    );

    trap_status_reg #(.DW(DW)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .set   (accepted),
        .third (third_byte),
        .wr    (stat_wr),
        .wval  (stat_wtrap),
        .stat  (stat),
        .rdata (stat_rdata)
    );

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk (
    input logic clk,
    input logic rst,
    input logic undef_fetch,
    input logic busy,
    input logic mem_we,
    input logic vec_load,
    input logic trap,
    input logic ufb
);

    // R2
    trap_set_chk: assert property (@(posedge clk) disable iff (rst)
        (undef_fetch && !busy) |=> trap);

    // R4
    push_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R5
    push_flow_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_we || vec_load));

    // R6
    vec_end_chk: assert property (@(posedge clk) disable iff (rst)
        vec_load |=> !busy);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_we);

    // R8
    ufb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ufb));

    // R9
    trap_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trap) |-> $past(undef_fetch));

endmodule

bind undef_trap_seq trap_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .undef_fetch (undef_fetch),
    .busy        (busy),
    .mem_we      (mem_we),
    .vec_load    (vec_load),
    .trap        (stat_rdata[0]),
    .ufb         (stat_rdata[1])
);

// File: tb/undef_trap_seq_test.sv
`timescale 1ns/1ps
module undef_trap_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        undef_fetch = 1'b0;
    logic        third_byte = 1'b0;
    logic [15:0] pc_in = '0;
    logic [15:0] sp_in = '0;
    logic        stat_wr = 1'b0;
    logic        stat_wtrap = 1'b0;
    logic [7:0]  stat_rdata;
    logic        busy, mem_we, sp_wr_en, vec_load;
    logic [15:0] mem_addr, sp_wr_val, vec_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    undef_trap_seq uut (
        .clk(clk), .rst(rst), .undef_fetch(undef_fetch), .third_byte(third_byte),
        .pc_in(pc_in), .sp_in(sp_in), .stat_wr(stat_wr), .stat_wtrap(stat_wtrap),
        .stat_rdata(stat_rdata), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sp_wr_en(sp_wr_en), .sp_wr_val(sp_wr_val),
        .vec_load(vec_load), .vec_addr(vec_addr)
    );

    // behavioural model: remaining-cycle count 3 = high push, 2 = low push, 1 = vector
    int          m_cnt = 0;
    bit          m_trap = 0, m_ufb = 0;
    logic [15:0] m_pc = '0, m_sp = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_trap <= 0; m_ufb <= 0;
        end else begin
            if (undef_fetch && m_cnt == 0) begin
                m_cnt <= 3; m_pc <= pc_in; m_sp <= sp_in; m_ufb <= third_byte;
                m_trap <= 1;
            end else begin
                if (m_cnt > 0) m_cnt <= m_cnt - 1;
                if (stat_wr && !stat_wtrap) m_trap <= 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [15:0] e_addr;
            logic [7:0]  e_data;
            e_addr = m_sp - 16'((m_cnt == 3) ? 1 : 2);
            e_data = (m_cnt == 3) ? m_pc[15:8] : m_pc[7:0];
            check(busy == (m_cnt != 0), "R7 busy", busy, m_cnt != 0);
            check(stat_rdata[0] == m_trap, "R2 trap flag", stat_rdata[0], m_trap);
            check(stat_rdata[1] == m_ufb, "R3 position bit", stat_rdata[1], m_ufb);
            check(stat_rdata[7:2] == 0, "R1 unused status bits", stat_rdata, 0);
            check(mem_we == (m_cnt >= 2), "R4 write enable", mem_we, m_cnt >= 2);
            check(vec_load == (m_cnt == 1), "R6 vector load", vec_load, m_cnt == 1);
            if (m_cnt >= 2) begin
                check(mem_addr == e_addr, "R4 push address", mem_addr, e_addr);
                check(mem_wdata == e_data, "R4 push data", mem_wdata, e_data);
                check(sp_wr_en && sp_wr_val == e_addr, "R5 sp update", sp_wr_val, e_addr);
            end else begin
                check(!sp_wr_en, "R5 sp idle", sp_wr_en, 0);
            end
            if (m_cnt == 1)
                check(vec_addr == 16'h0000, "R6 vector address", vec_addr, 0);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fire(input logic [15:0] pc, input logic [15:0] sp, input bit third);
        undef_fetch = 1; pc_in = pc; sp_in = sp; third_byte = third;
        tick(1);
        undef_fetch = 0;
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        check(stat_rdata == 0, "R1 status after reset", stat_rdata, 0);
        check(!busy && !mem_we && !sp_wr_en && !vec_load, "R1 idle outputs",
              {busy, mem_we, sp_wr_en, vec_load}, 0);

        // bad second byte
        fire(16'h1234, 16'h8000, 0);
        check(mem_addr == 16'h7FFF && mem_wdata == 8'h12, "R4 high byte first",
              {mem_addr, mem_wdata}, {16'h7FFF, 8'h12});
        tick(1);
        check(sp_wr_val == 16'h7FFE && mem_wdata == 8'h34, "R5 final sp",
              {sp_wr_val, mem_wdata}, {16'h7FFE, 8'h34});
        tick(4);

        // R9 write 1 has no effect, write 0 clears
        stat_wr = 1; stat_wtrap = 1; tick(1);
        stat_wr = 0;
        check(stat_rdata[0] == 1, "R9 write one ignored", stat_rdata[0], 1);
        stat_wr = 1; stat_wtrap = 0; tick(1);
        stat_wr = 0;
        check(stat_rdata[0] == 0 && stat_rdata[1] == 0, "R9 write zero clears",
              stat_rdata[1:0], 0);

        // bad third byte with a strobe while busy
        fire(16'hBEEF, 16'h0101, 1);
        check(stat_rdata[1] == 1, "R3 third byte sets position", stat_rdata[1], 1);
        undef_fetch = 1; pc_in = 16'h5555; sp_in = 16'h4000; third_byte = 0;
        tick(1);
        undef_fetch = 0;
        check(mem_addr == 16'h00FF && mem_wdata == 8'hEF, "R8 busy strobe ignored",
              {mem_addr, mem_wdata}, {16'h00FF, 8'hEF});
        check(stat_rdata[1] == 1, "R8 position kept", stat_rdata[1], 1);
        tick(1);
        check(vec_load == 1, "R6 vector after push", vec_load, 1);
        tick(3);

        // R10 set wins over simultaneous clear
        stat_wr = 1; stat_wtrap = 0; undef_fetch = 1; pc_in = 16'h0A0B; sp_in = 16'h0001;
        third_byte = 0;
        tick(1);
        stat_wr = 0; undef_fetch = 0;
        check(stat_rdata[0] == 1, "R10 trap beats clear", stat_rdata[0], 1);
        tick(1);
        check(sp_wr_val == 16'hFFFF, "R5 sp wraps", sp_wr_val, 16'hFFFF);
        tick(4);

        // strobe held high: retaken only when idle
        undef_fetch = 1; pc_in = 16'hC0DE; sp_in = 16'h2000; third_byte = 1;
        tick(9);
        undef_fetch = 0;
        tick(5);

        // reset in mid-sequence
        fire(16'h7777, 16'h3000, 1);
        rst = 1; tick(1); rst = 0;
        check(stat_rdata == 0 && !busy, "R1 reset mid-sequence", {stat_rdata, busy}, 0);
        tick(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule